// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps wall-clock time and date in packed BCD. A one-cycle pulse on `tick_i`, once per second, advances seconds, minutes and hours. At midnight the calendar advances: date, day of week, month, year of century and century. Month lengths and leap years are handled in hardware across the years 1900 to 2099. Host software reaches four 32-bit words through a small register bus. Writes complete in one cycle, and the read data is a combinational function of the address.

To load a new time or date, software sets one or both update-request bits in the control word. The matching counters stop advancing. At the next seconds tick the block raises an acknowledge flag. From then on the frozen words accept writes. Clearing the request bits lets counting resume from the written values. The block also raises a one-cycle pulse and a sticky status flag for every second, every minute rollover and every day rollover.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset, the time word reads 00:00:00 (0x00000000). The calendar word reads century 20, year 00, month 01, date 01, day of week 7 (0x01E10020). The control and status words read 0.
- R2: The time word is read at address 2 and holds seconds in bits 6:0, minutes in bits 14:8 and hours in bits 21:16, each in packed BCD. Bit 22 and the other unused bits read 0. On an advancing tick, seconds step from 59 to 00 and carry into minutes. Minutes step from 59 to 00 and carry into hours. Hours step from 23 to 00 and carry into the calendar.
- R3: The calendar word is read at address 3 and holds century in bits 6:0, year in bits 15:8, month in bits 20:16, day of week in bits 23:21 and date in bits 29:24, each in packed BCD. The date wraps to 01 after the last day of the month. April, June, September and November have 30 days; the other months apart from February have 31. Month wraps from 12 to 01 and advances the year. Year wraps from 99 to 00 and advances the century. Both words change on the same clock edge.
- R4: February has 29 days when the year is a nonzero multiple of 4, or when the year is 00 and the century is 20. Otherwise it has 28.
- R5: The day of week steps with every date advance and wraps from 7 to 1.
- R6: The control word is at address 0. While bit 0 is set, ticks do not advance the time word. While bit 1 is set, day carries do not advance the calendar word. The other counter keeps running.
- R7: The first tick after a request bit becomes set raises acknowledge, status bit 0. A write to the time or calendar word is accepted only when its request bit is set and that acknowledge has occurred. Any other write to those words is ignored.
- R8: Once both request bits are cleared, the next tick counts on from the written values.
- R9: Every tick sets status bit 2 and drives `sec_pulse_o` high for exactly the following cycle.
- R10: Every minute rollover, where seconds go from 59 to 00, sets status bit 3 and pulses `min_evt_o` for one cycle.
- R11: Every day rollover, where the time wraps from 23:59:59 to 00:00:00, sets status bit 4 and pulses `day_evt_o` for one cycle.
- R12: The status word is at address 1. Writing to it clears each flag whose write-data bit is 1. An event that sets a flag in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | One-cycle pulse per second |
| bus_wr_i | input | 1 | Write strobe for the register bus |
| bus_addr_i | input | 2 | Word address: 0 control, 1 status, 2 time, 3 calendar |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| sec_pulse_o | output | 1 | One-cycle pulse after each tick |
| min_evt_o | output | 1 | One-cycle pulse on a minute rollover |
| day_evt_o | output | 1 | One-cycle pulse on a day rollover |

## Verification
Each tick or bus write is sampled on one rising edge. Every result it causes is due right after that same edge: counter words, status flags, request and acknowledge state, and the three pulses. Reads cost no cycle, since the read data follows the address combinationally. The bench drives inputs on the falling edge. Its model steps at the rising edge from those same inputs, and the read data and pulses are compared 1 ns after that edge. Directed reads happen mid-cycle, after the edge that produced the state.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_TIME = 2'd2,
    REG_CAL  = 2'd3
  } rtc_reg_e;

  localparam int unsigned ST_W   = 5;
  localparam int unsigned ST_ACK = 0;
  localparam int unsigned ST_SEC = 2;
  localparam int unsigned ST_TIM = 3;
  localparam int unsigned ST_CAL = 4;

  typedef struct packed {
    logic [5:0] hr;
    logic [6:0] min;
    logic [6:0] sec;
  } rtc_tod_t;

  typedef struct packed {
    logic [5:0] date;
    logic [2:0] dow;
    logic [4:0] mon;
    logic [7:0] yr;
    logic [6:0] cent;
  } rtc_cal_t;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic is_leap(input logic [7:0] yr, input logic [7:0] cent);
    logic [6:0] yb;
    yb = 7'(yr[7:4]) * 7'd10 + 7'(yr[3:0]);
    if (yb == 7'd0) return (cent == 8'h20);
    return (yb[1:0] == 2'b00);
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] mon, input logic leap);
    case (mon)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic logic [31:0] pack_tod(input rtc_tod_t t);
    return {10'd0, t.hr, 1'b0, t.min, 1'b0, t.sec};
  endfunction

  function automatic logic [31:0] pack_cal(input rtc_cal_t c);
    return {2'd0, c.date, c.dow, c.mon, c.yr, 1'b0, c.cent};
  endfunction

endpackage

// File: rtl/rtc_bcd_step.sv
module rtc_bcd_step
  import rtc_pkg::*;
#(
  parameter logic [7:0] LO = 8'h00
) (
  input  logic [7:0] cur_i,
  input  logic [7:0] lim_i,
  input  logic       inc_i,
  output logic [7:0] nxt_o,
  output logic       wrap_o
);

  assign wrap_o = inc_i && (cur_i == lim_i);

  always_comb begin
    if (!inc_i)      nxt_o = cur_i;
    else if (wrap_o) nxt_o = LO;
    else             nxt_o = bcd_inc(cur_i);
  end

endmodule

// File: rtl/rtc_time_cnt.sv
module rtc_time_cnt
  import rtc_pkg::*;
(
  input  rtc_tod_t tod_i,
  input  logic     adv_i,
  output rtc_tod_t tod_o,
  output logic     min_roll_o,
  output logic     day_roll_o
);

  localparam int NF = 3;
  localparam logic [7:0] LIM [NF] = '{8'h59, 8'h59, 8'h23};

  logic [7:0]  cur [NF];
  logic [7:0]  nxt [NF];
  logic [NF:0] carry;

  assign cur[0]   = {1'b0, tod_i.sec};
  assign cur[1]   = {1'b0, tod_i.min};
  assign cur[2]   = {2'b0, tod_i.hr};
  assign carry[0] = adv_i;

  for (genvar g = 0; g < NF; g++) begin : g_fld
    rtc_bcd_step #(.LO(8'h00)) u_step (
      .cur_i  (cur[g]),
      .lim_i  (LIM[g]),
      .inc_i  (carry[g]),
      .nxt_o  (nxt[g]),
      .wrap_o (carry[g+1])
    );
  end

  assign tod_o.sec  = nxt[0][6:0];
  assign tod_o.min  = nxt[1][6:0];
  assign tod_o.hr   = nxt[2][5:0];
  assign min_roll_o = carry[1];
  assign day_roll_o = carry[NF];

  logic unused_hi;
  assign unused_hi = ^{nxt[0][7], nxt[1][7], nxt[2][7:6]};

endmodule

// File: rtl/rtc_cal_cnt.sv
module rtc_cal_cnt
  import rtc_pkg::*;
(
  input  rtc_cal_t cal_i,
  input  logic     adv_i,
  output rtc_cal_t cal_o
);

  logic       leap;
  logic [7:0] mlen;
  logic       d_wrap, m_wrap, y_wrap, unused_cwrap, unused_wwrap;
  logic [7:0] dow_n, date_n, mon_n, yr_n, cent_n;

  assign leap = is_leap(cal_i.yr, {1'b0, cal_i.cent});
  assign mlen = month_len({3'b0, cal_i.mon}, leap);

  rtc_bcd_step #(.LO(8'h01)) u_dow (
    .cur_i({5'b0, cal_i.dow}), .lim_i(8'h07), .inc_i(adv_i),
    .nxt_o(dow_n), .wrap_o(unused_wwrap));

  rtc_bcd_step #(.LO(8'h01)) u_date (
    .cur_i({2'b0, cal_i.date}), .lim_i(mlen), .inc_i(adv_i),
    .nxt_o(date_n), .wrap_o(d_wrap));

  rtc_bcd_step #(.LO(8'h01)) u_mon (
    .cur_i({3'b0, cal_i.mon}), .lim_i(8'h12), .inc_i(d_wrap),
    .nxt_o(mon_n), .wrap_o(m_wrap));

  rtc_bcd_step #(.LO(8'h00)) u_yr (
    .cur_i(cal_i.yr), .lim_i(8'h99), .inc_i(m_wrap),
    .nxt_o(yr_n), .wrap_o(y_wrap));

  rtc_bcd_step #(.LO(8'h00)) u_cent (
    .cur_i({1'b0, cal_i.cent}), .lim_i(8'h99), .inc_i(y_wrap),
    .nxt_o(cent_n), .wrap_o(unused_cwrap));

  assign cal_o.dow  = dow_n[2:0];
  assign cal_o.date = date_n[5:0];
  assign cal_o.mon  = mon_n[4:0];
  assign cal_o.yr   = yr_n;
  assign cal_o.cent = cent_n[6:0];

  logic unused_hi;
  assign unused_hi = ^{dow_n[7:3], date_n[7:6], mon_n[7:5], cent_n[7]};

endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
  import rtc_pkg::*;
#(
  parameter int unsigned RST_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_i,
  input  logic        bus_wr_i,
  input  logic [1:0]  bus_addr_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o,
  output logic        sec_pulse_o,
  output logic        min_evt_o,
  output logic        day_evt_o
);

  localparam rtc_tod_t TOD_RST = '{hr: 6'h00, min: 7'h00, sec: 7'h00};
  localparam rtc_cal_t CAL_RST = '{date: 6'h01, dow: 3'd7, mon: 5'h01, yr: 8'h00, cent: 7'h20};

  // reset: asserted asynchronously, released on the clock
  logic [RST_STAGES-1:0] rs_q;
  logic                  rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rs_q[RST_STAGES-1];

  // state
  rtc_tod_t        tod_q, tod_n, tod_step;
  rtc_cal_t        cal_q, cal_n, cal_step;
  logic [1:0]      req_q, req_n;
  logic            ackg_q, ackg_n;
  logic [ST_W-1:0] st_q, st_n, st_set, st_clr;
  logic            sec_q, min_q, day_q;

  logic adv_tod, adv_cal, min_roll, day_roll;
  logic wr_ctrl, wr_stat, wr_tod, wr_cal;
  logic tod_en, cal_en;

  assign adv_tod = tick_i & ~req_q[0];

  rtc_time_cnt u_time (
    .tod_i      (tod_q),
    .adv_i      (adv_tod),
    .tod_o      (tod_step),
    .min_roll_o (min_roll),
    .day_roll_o (day_roll)
  );

  assign adv_cal = day_roll & ~req_q[1];

  rtc_cal_cnt u_cal (
    .cal_i (cal_q),
    .adv_i (adv_cal),
    .cal_o (cal_step)
  );

  // bus decode
  assign wr_ctrl = bus_wr_i && (bus_addr_i == REG_CTRL);
  assign wr_stat = bus_wr_i && (bus_addr_i == REG_STAT);
  assign wr_tod  = bus_wr_i && (bus_addr_i == REG_TIME) && req_q[0] && ackg_q;
  assign wr_cal  = bus_wr_i && (bus_addr_i == REG_CAL)  && req_q[1] && ackg_q;

  always_comb begin
    st_set         = '0;
    st_set[ST_SEC] = tick_i;
    st_set[ST_ACK] = tick_i && (req_q != 2'b00) && !ackg_q;
    st_set[ST_TIM] = min_roll;
    st_set[ST_CAL] = day_roll;
    st_clr         = wr_stat ? bus_wdata_i[ST_W-1:0] : '0;
    st_n           = (st_q & ~st_clr) | st_set;

    if (req_q == 2'b00) ackg_n = 1'b0;
    else if (tick_i)    ackg_n = 1'b1;
    else                ackg_n = ackg_q;

    req_n = wr_ctrl ? bus_wdata_i[1:0] : req_q;

    if (wr_tod) begin
      tod_n.hr  = bus_wdata_i[21:16];
      tod_n.min = bus_wdata_i[14:8];
      tod_n.sec = bus_wdata_i[6:0];
    end else begin
      tod_n = tod_step;
    end

    if (wr_cal) begin
      cal_n.date = bus_wdata_i[29:24];
      cal_n.dow  = bus_wdata_i[23:21];
      cal_n.mon  = bus_wdata_i[20:16];
      cal_n.yr   = bus_wdata_i[15:8];
      cal_n.cent = bus_wdata_i[6:0];
    end else begin
      cal_n = cal_step;
    end

    tod_en = adv_tod | wr_tod;
    cal_en = adv_cal | wr_cal;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      tod_q  <= TOD_RST;
      cal_q  <= CAL_RST;
      req_q  <= '0;
      ackg_q <= 1'b0;
      st_q   <= '0;
      sec_q  <= 1'b0;
      min_q  <= 1'b0;
      day_q  <= 1'b0;
    end else begin
      if (tod_en) tod_q <= tod_n;
      if (cal_en) cal_q <= cal_n;
      req_q  <= req_n;
      ackg_q <= ackg_n;
      st_q   <= st_n;
      sec_q  <= tick_i;
      min_q  <= min_roll;
      day_q  <= day_roll;
    end
  end

  always_comb begin
    case (bus_addr_i)
      REG_CTRL: bus_rdata_o = {30'd0, req_q};
      REG_STAT: bus_rdata_o = {{(32-ST_W){1'b0}}, st_q};
      REG_TIME: bus_rdata_o = pack_tod(tod_q);
      REG_CAL:  bus_rdata_o = pack_cal(cal_q);
      default:  bus_rdata_o = '0;
    endcase
  end

  assign sec_pulse_o = sec_q;
  assign min_evt_o   = min_q;
  assign day_evt_o   = day_q;

  logic unused_wdata;
  assign unused_wdata = ^{bus_wdata_i[31:30], bus_wdata_i[7]};

endmodule

// File: rtl/bcd_rtc_core_chk.sv
module bcd_rtc_core_chk
  import rtc_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            tick_i,
  input logic            wr_i,
  input logic [1:0]      addr_i,
  input logic [1:0]      req_q,
  input logic [ST_W-1:0] st_q,
  input rtc_tod_t        tod_q,
  input rtc_cal_t        cal_q,
  input logic            sec_pulse_o,
  input logic            min_evt_o,
  input logic            day_evt_o
);

  AST_ACK_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q[ST_ACK]) |-> ($past(tick_i) && ($past(req_q) != 2'b00))); // R7

  AST_TOD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q[0] && !(wr_i && addr_i == REG_TIME)) |=> $stable(tod_q)); // R6

  AST_CAL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q[1] && !(wr_i && addr_i == REG_CAL)) |=> $stable(cal_q)); // R6

  AST_SEC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> (sec_pulse_o && st_q[ST_SEC])); // R9

  AST_NO_STRAY_SEC: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> !sec_pulse_o); // R9

  AST_MIN_EVT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    min_evt_o |-> (tod_q.sec == 7'h00 && st_q[ST_TIM])); // R10

  AST_DAY_EVT_MIDNIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    day_evt_o |-> (tod_q == '0 && st_q[ST_CAL])); // R11

endmodule

bind bcd_rtc_core bcd_rtc_core_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .tick_i      (tick_i),
  .wr_i        (bus_wr_i),
  .addr_i      (bus_addr_i),
  .req_q       (req_q),
  .st_q        (st_q),
  .tod_q       (tod_q),
  .cal_q       (cal_q),
  .sec_pulse_o (sec_pulse_o),
  .min_evt_o   (min_evt_o),
  .day_evt_o   (day_evt_o)
);

// File: tb/bcd_rtc_core_tb.sv
`timescale 1ns/1ps
module bcd_rtc_core_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        sec_p, min_p, day_p;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bcd_rtc_core u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .bus_wr_i(wr), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .sec_pulse_o(sec_p),
    .min_evt_o(min_p), .day_evt_o(day_p));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mktime(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
    return {10'd0, h[5:0], 1'b0, m[6:0], 1'b0, s[6:0]};
  endfunction

  function automatic logic [31:0] mkcal(input logic [7:0] dt, input logic [2:0] dw,
                                        input logic [7:0] mo, input logic [7:0] yr, input logic [7:0] ce);
    return {2'd0, dt[5:0], dw, mo[4:0], yr, 1'b0, ce[6:0]};
  endfunction

  function automatic int b2i(input logic [7:0] v);
    return int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction

  function automatic logic [31:0] i2b(input int v);
    return 32'((v / 10) * 16 + (v % 10));
  endfunction

  function automatic int mdays(input int mo, input int yr, input int ce);
    if (mo == 2) return (((yr != 0) && (yr % 4 == 0)) || ((yr == 0) && (ce == 20))) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  // behavioural reference model
  int ms, mm, mh, mdt, mmo, myr, mce, mdw;
  logic [1:0] mreq, oreq;
  bit mack, oack, dayc, ep_sec, ep_min, ep_day;
  logic [4:0] mst, sset, sclr;

  function automatic logic [31:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0: return {30'd0, mreq};
      2'd1: return {27'd0, mst};
      2'd2: return i2b(ms) | (i2b(mm) << 8) | (i2b(mh) << 16);
      default: return i2b(mce) | (i2b(myr) << 8) | (i2b(mmo) << 16)
                    | (32'(mdw) << 21) | (i2b(mdt) << 24);
    endcase
  endfunction

  function automatic string tag_of(input logic [1:0] a);
    case (a)
      2'd0: return "R6 control";
      2'd1: return "R12 status";
      2'd2: return "R2 time word";
      default: return "R3 calendar word";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      ms = 0; mm = 0; mh = 0; mdt = 1; mmo = 1; myr = 0; mce = 20; mdw = 7;
      mreq = 2'b00; mack = 1'b0; mst = '0; ep_sec = 0; ep_min = 0; ep_day = 0;
    end else begin
      oreq = mreq; oack = mack; sset = '0; sclr = '0; dayc = 0;
      ep_sec = tick; ep_min = 0; ep_day = 0;
      if (tick) begin
        sset[2] = 1'b1;
        if (oreq != 2'b00 && !oack) sset[0] = 1'b1;
      end
      if (oreq == 2'b00) mack = 1'b0;
      else if (tick)     mack = 1'b1;
      if (tick && !oreq[0]) begin
        ms++;
        if (ms == 60) begin
          ms = 0; ep_min = 1; sset[3] = 1'b1; mm++;
          if (mm == 60) begin
            mm = 0; mh++;
            if (mh == 24) begin mh = 0; dayc = 1; ep_day = 1; sset[4] = 1'b1; end
          end
        end
      end
      if (dayc && !oreq[1]) begin
        mdw = (mdw == 7) ? 1 : mdw + 1;
        if (mdt == mdays(mmo, myr, mce)) begin
          mdt = 1;
          if (mmo == 12) begin
            mmo = 1;
            if (myr == 99) begin myr = 0; mce++; end
            else myr++;
          end else mmo++;
        end else mdt++;
      end
      if (wr) begin
        case (addr)
          2'd0: mreq = wdata[1:0];
          2'd1: sclr = wdata[4:0];
          2'd2: if (oreq[0] && oack) begin
                  ms = b2i({1'b0, wdata[6:0]}); mm = b2i({1'b0, wdata[14:8]});
                  mh = b2i({2'b0, wdata[21:16]});
                end
          default: if (oreq[1] && oack) begin
                  mce = b2i({1'b0, wdata[6:0]}); myr = b2i(wdata[15:8]);
                  mmo = b2i({3'b0, wdata[20:16]}); mdw = int'(wdata[23:21]);
                  mdt = b2i({2'b0, wdata[29:24]});
                end
        endcase
      end
      mst = (mst & ~sclr) | sset;
    end
    #1;
    check(tag_of(addr), rdata, exp_rd(addr));
    check("R9 sec pulse", {31'd0, sec_p}, {31'd0, ep_sec});
    check("R10 minute pulse", {31'd0, min_p}, {31'd0, ep_min});
    check("R11 day pulse", {31'd0, day_p}, {31'd0, ep_day});
  end

  // stimulus helpers
  task automatic do_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); wr = 1'b0; addr = a;
    #1; d = rdata;
  endtask

  task automatic set_clock(input logic [31:0] t, input logic [31:0] c);
    wr_reg(2'd0, 32'd3);
    do_tick();
    wr_reg(2'd2, t);
    wr_reg(2'd3, c);
    wr_reg(2'd0, 32'd0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v, t0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset values
    rd_reg(2'd2, v); check("R1 time", v, 32'h0000_0000);
    rd_reg(2'd3, v); check("R1 calendar", v, mkcal(8'h01, 3'd7, 8'h01, 8'h00, 8'h20));
    rd_reg(2'd0, v); check("R1 control", v, 32'd0);
    rd_reg(2'd1, v); check("R1 status", v, 32'd0);

    // R2 / R9 / R10 plain counting
    for (int i = 0; i < 70; i++) do_tick();
    rd_reg(2'd2, v); check("R2 70 s", v, mktime(8'h00, 8'h01, 8'h10));
    rd_reg(2'd1, v); check("R9 R10 status", v, 32'h0000_000C);

    // R12 clear, event wins over clear
    wr_reg(2'd1, 32'h1F);
    rd_reg(2'd1, v); check("R12 all cleared", v, 32'd0);
    @(negedge clk); tick = 1'b1; wr = 1'b1; addr = 2'd1; wdata = 32'h04;
    @(negedge clk); tick = 1'b0; wr = 1'b0;
    rd_reg(2'd1, v); check("R12 set wins", v, 32'h04);
    wr_reg(2'd1, 32'h08);
    rd_reg(2'd1, v); check("R12 other bits kept", v, 32'h04);

    // R7 writes ignored without request
    rd_reg(2'd2, t0);
    wr_reg(2'd2, mktime(8'h01, 8'h02, 8'h03));
    rd_reg(2'd2, v); check("R7 write without request", v, t0);

    // R7 request but not yet acknowledged
    wr_reg(2'd0, 32'd1);
    wr_reg(2'd2, mktime(8'h01, 8'h02, 8'h03));
    rd_reg(2'd2, v); check("R7 write before ack", v, t0);
    rd_reg(2'd1, v); check("R7 no ack before tick", v & 32'h1, 32'd0);
    do_tick(); do_tick();
    rd_reg(2'd2, v); check("R6 time frozen", v, t0);
    rd_reg(2'd1, v); check("R7 ack raised", v & 32'h1, 32'd1);
    wr_reg(2'd2, mktime(8'h12, 8'h34, 8'h56));
    rd_reg(2'd2, v); check("R7 write accepted", v, mktime(8'h12, 8'h34, 8'h56));
    wr_reg(2'd0, 32'd0);
    do_tick();
    rd_reg(2'd2, v); check("R8 resume", v, mktime(8'h12, 8'h34, 8'h57));

    // R2 hour carry
    set_clock(mktime(8'h00, 8'h59, 8'h59), mkcal(8'h10, 3'd2, 8'h03, 8'h24, 8'h20));
    do_tick();
    rd_reg(2'd2, v); check("R2 hour carry", v, mktime(8'h01, 8'h00, 8'h00));

    // R4 leap in 2000, R8 resume, R11 status
    set_clock(mktime(8'h23, 8'h59, 8'h58), mkcal(8'h28, 3'd2, 8'h02, 8'h00, 8'h20));
    do_tick();
    rd_reg(2'd2, v); check("R8 first tick", v, mktime(8'h23, 8'h59, 8'h59));
    do_tick();
    rd_reg(2'd2, v); check("R2 midnight", v, 32'd0);
    rd_reg(2'd3, v); check("R4 2000 leap", v, mkcal(8'h29, 3'd3, 8'h02, 8'h00, 8'h20));
    rd_reg(2'd1, v); check("R11 cal flag", (v >> 4) & 32'h1, 32'd1);

    // R4 1900 not leap
    set_clock(mktime(8'h23, 8'h59, 8'h59), mkcal(8'h28, 3'd2, 8'h02, 8'h00, 8'h19));
    do_tick();
    rd_reg(2'd3, v); check("R4 1900", v, mkcal(8'h01, 3'd3, 8'h03, 8'h00, 8'h19));

    // R4 2004 leap, 2001 not
    set_clock(mktime(8'h23, 8'h59, 8'h59), mkcal(8'h28, 3'd5, 8'h02, 8'h04, 8'h20));
    do_tick();
    rd_reg(2'd3, v); check("R4 2004", v, mkcal(8'h29, 3'd6, 8'h02, 8'h04, 8'h20));
    set_clock(mktime(8'h23, 8'h59, 8'h59), mkcal(8'h28, 3'd5, 8'h02, 8'h01, 8'h20));
    do_tick();
    rd_reg(2'd3, v); check("R4 2001", v, mkcal(8'h01, 3'd6, 8'h03, 8'h01, 8'h20));

    // R3 / R5 year and century wrap, day of week wrap
    set_clock(mktime(8'h23, 8'h59, 8'h59), mkcal(8'h31, 3'd7, 8'h12, 8'h99, 8'h19));
    do_tick();
    rd_reg(2'd3, v); check("R3 R5 century wrap", v, mkcal(8'h01, 3'd1, 8'h01, 8'h00, 8'h20));

    // R3 thirty-day month
    set_clock(mktime(8'h23, 8'h59, 8'h59), mkcal(8'h30, 3'd4, 8'h04, 8'h10, 8'h20));
    do_tick();
    rd_reg(2'd3, v); check("R3 April", v, mkcal(8'h01, 3'd5, 8'h05, 8'h10, 8'h20));

    // R6 calendar-only request: time runs, date holds
    set_clock(mktime(8'h23, 8'h59, 8'h59), mkcal(8'h15, 3'd3, 8'h06, 8'h24, 8'h20));
    wr_reg(2'd0, 32'd2);
    do_tick();
    rd_reg(2'd2, v); check("R6 time runs", v, 32'd0);
    rd_reg(2'd3, v); check("R6 calendar held", v, mkcal(8'h15, 3'd3, 8'h06, 8'h24, 8'h20));
    wr_reg(2'd0, 32'd0);
    repeat (4) @(negedge clk);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule